// File: doc/BRIEF.md
# NaN-boxed sign-injection unit

This block carries out the three single-precision sign-injection operations (copy sign, copy inverted sign, and sign exclusive-or) on wide floating-point register values that hold a narrow value in NaN-boxed form. In NaN-boxed form, every bit above the narrow value is set to one. Each operand is first checked for valid boxing. An operand that fails the check is treated as the canonical quiet NaN. The block then combines the sign bit and the magnitude bits, and re-boxes the result, so that the written-back value is always properly boxed.

The datapath sits beside the floating-point register file. On each cycle it takes two register values, an operation select and a valid strobe. One cycle after an accepted input, it presents a registered result with a valid flag and a one-cycle pulse that marks the floating-point state as dirty. When both sources name the same register, the two operands are identical. The three operations then act as move, negate and absolute value without any special handling.

Top module: `nanbox_sgnj`

## Requirements
- R1: An operand whose upper FLEN-SLEN bits (63..32 by default) are all ones is correctly boxed, and its low SLEN bits are used unchanged.
- R2: An operand whose upper bits are not all ones is replaced by the canonical quiet NaN, 0x7FC00000 in the low 32 bits, before the operation.
- R3: Select 2'b00 (copy sign): result bit 31 is operand B's sign and bits 30..0 are operand A's magnitude.
- R4: Select 2'b01 (inverted sign): result bit 31 is the inverse of operand B's sign and bits 30..0 are operand A's magnitude.
- R5: Select 2'b10 (sign xor): result bit 31 is A's sign XOR B's sign and bits 30..0 are operand A's magnitude.
- R6: Bits 63..32 of every result are all ones, including when the canonical NaN was substituted.
- R7: With equal operands, the three selects give move, negate (bit 31 flipped) and absolute value (bit 31 cleared) of the unboxed operand.
- R8: Select 2'b11 is reserved. It, or an idle cycle, produces no valid and no dirty pulse in the next cycle, and the result output holds its previous value.
- R9: An accepted input makes the result, out_valid and fs_dirty appear exactly one clock later. Each flag is high for one cycle per accepted input.
- R10: A synchronous active-high reset clears out_valid, fs_dirty and out_data to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| op_sel | input | 2 | 00 copy sign, 01 inverted sign, 10 sign xor, 11 reserved |
| src_a | input | FLEN (64) | Operand supplying magnitude |
| src_b | input | FLEN (64) | Operand supplying sign |
| out_valid | output | 1 | Result valid, one cycle after acceptance |
| out_data | output | FLEN (64) | Registered boxed result |
| fs_dirty | output | 1 | Floating-point state dirty pulse |

## Verification
The bench builds the block with its defaults: 64-bit registers, a 32-bit narrow format and an 8-bit exponent. With these values the canonical NaN is 0x7FC00000. That brings into reach the cases where a box pattern is only one bit short of all ones, and the cases where the substituted NaN's zero sign meets each sign rule. Random operands mix boxed values, infinities, NaNs and unboxed patterns, and drawing both operands from one value exercises the move, negate and absolute-value cases.

// File: rtl/nanbox_sgnj.sv
module nanbox_sgnj #(
  parameter int FLEN  = 64,
  parameter int SLEN  = 32,
  parameter int EXP_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [1:0]      op_sel,
  input  logic [FLEN-1:0] src_a,
  input  logic [FLEN-1:0] src_b,
  output logic            out_valid,
  output logic [FLEN-1:0] out_data,
  output logic            fs_dirty
);
  localparam int BOX_W = FLEN - SLEN;
  localparam int SGN   = SLEN - 1;
  localparam logic [SLEN-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(SLEN-EXP_W-2){1'b0}}};

  function automatic logic [SLEN-1:0] unbox(input logic [FLEN-1:0] v);
    return (&v[FLEN-1:SLEN]) ? v[SLEN-1:0] : QNAN;
  endfunction

  logic [SLEN-1:0] a_n, b_n;
  logic            sgn;
  logic            take;

  assign a_n  = unbox(src_a);
  assign b_n  = unbox(src_b);
  assign take = in_valid && (op_sel != 2'b11);

  always_comb begin
    case (op_sel)
      2'b00:   sgn = b_n[SGN];
      2'b01:   sgn = ~b_n[SGN];
      2'b10:   sgn = a_n[SGN] ^ b_n[SGN];
      default: sgn = a_n[SGN];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      fs_dirty  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= take;
      fs_dirty  <= take;
      if (take)
        out_data <= {{BOX_W{1'b1}}, sgn, a_n[SGN-1:0]};
    end
  end
endmodule

// File: rtl/nanbox_sgnj_chk.sv
module nanbox_sgnj_chk #(
  parameter int FLEN  = 64,
  parameter int SLEN  = 32,
  parameter int EXP_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [1:0]      op_sel,
  input logic [FLEN-1:0] src_a,
  input logic [FLEN-1:0] src_b,
  input logic            out_valid,
  input logic [FLEN-1:0] out_data,
  input logic            fs_dirty
);
  localparam int SGN = SLEN - 1;
  localparam logic [SLEN-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(SLEN-EXP_W-2){1'b0}}};

  logic            a_ok, b_ok, acc;
  logic [SLEN-1:0] a_e, b_e;
  assign a_ok = &src_a[FLEN-1:SLEN];
  assign b_ok = &src_b[FLEN-1:SLEN];
  assign a_e  = a_ok ? src_a[SLEN-1:0] : QNAN;
  assign b_e  = b_ok ? src_b[SLEN-1:0] : QNAN;
  assign acc  = in_valid && (op_sel != 2'b11);

  AST_BOXED_MAG: assert property (@(posedge clk) disable iff (rst)
    acc && a_ok |=> out_data[SGN-1:0] == $past(src_a[SGN-1:0])); // R1
  AST_CANON_SUB: assert property (@(posedge clk) disable iff (rst)
    acc && !a_ok |=> out_data[SGN-1:0] == QNAN[SGN-1:0]); // R2
  AST_COPY_SIGN: assert property (@(posedge clk) disable iff (rst)
    in_valid && op_sel == 2'b00 |=> out_data[SGN] == $past(b_e[SGN])); // R3
  AST_INV_SIGN: assert property (@(posedge clk) disable iff (rst)
    in_valid && op_sel == 2'b01 |=> out_data[SGN] != $past(b_e[SGN])); // R4
  AST_XOR_SIGN: assert property (@(posedge clk) disable iff (rst)
    in_valid && op_sel == 2'b10 |=> out_data[SGN] == ($past(a_e[SGN]) ^ $past(b_e[SGN]))); // R5
  AST_OUT_BOXED: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> &out_data[FLEN-1:SLEN]); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !out_valid && !fs_dirty && $stable(out_data)); // R8
  AST_ONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid && fs_dirty); // R9
endmodule

bind nanbox_sgnj nanbox_sgnj_chk #(.FLEN(FLEN), .SLEN(SLEN), .EXP_W(EXP_W)) u_chk (.*);

// File: tb/tb_nanbox_sgnj.sv
module tb_nanbox_sgnj;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic [63:0] src_a = '0, src_b = '0;
  logic        out_valid, fs_dirty;
  logic [63:0] out_data;

  int checks = 0, fails = 0;
  logic [63:0] last = '0;

  nanbox_sgnj dut (.clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
                   .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
                   .out_data(out_data), .fs_dirty(fs_dirty));

  always #10 clk = ~clk;

  function automatic logic [31:0] eff(input logic [63:0] v);
    if (v[63:32] == 32'hFFFF_FFFF) return v[31:0];
    return 32'h7FC0_0000;
  endfunction

  function automatic logic [63:0] model(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
    logic [31:0] x = eff(a), y = eff(b);
    logic s;
    case (op)
      2'b00:   s = y[31];
      2'b01:   s = !y[31];
      default: s = x[31] ^ y[31];
    endcase
    return {32'hFFFF_FFFF, s, x[30:0]};
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input string tag, input logic v, input logic [1:0] op,
                       input logic [63:0] a, input logic [63:0] b, input logic [63:0] exp_fixed,
                       input logic use_fixed);
    logic acc = v && (op != 2'b11);
    logic [63:0] exp = use_fixed ? exp_fixed : (acc ? model(op, a, b) : last);
    @(negedge clk);
    in_valid = v; op_sel = op; src_a = a; src_b = b;
    @(posedge clk);
    #5;
    chk({tag, " data"}, out_data, exp);
    chk({tag, " valid/dirty R9"}, {62'd0, out_valid, fs_dirty}, {62'd0, acc, acc});
    last = exp;
  endtask

  function automatic logic [63:0] pick();
    logic [31:0] r = $urandom;
    case ($urandom % 7)
      0: return {32'hFFFF_FFFF, r};
      1: return {32'hFFFF_FFFF, r[31], 31'h7F80_0000};
      2: return {32'hFFFF_FFFF, r[31], 8'hFF, 1'b1, r[21:0]};
      3: return {32'hFFFF_FFFE, r};
      4: return {r, r};
      5: return {32'h0000_0000, r};
      default: return {32'hFFFF_FFFF, r[31], 8'hFF, 1'b0, r[21:0] | 22'd1};
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #5;
    chk("R10 reset data", out_data, 64'd0);
    chk("R10 reset flags", {62'd0, out_valid, fs_dirty}, 64'd0);
    @(negedge clk); rst = 1'b0;

    apply("R3 R1 copy sign", 1, 2'b00, 64'hFFFFFFFF_3F800000, 64'hFFFFFFFF_C0000000, 64'hFFFFFFFF_BF800000, 1);
    apply("R4 inverted sign", 1, 2'b01, 64'hFFFFFFFF_3F800000, 64'hFFFFFFFF_C0000000, 64'hFFFFFFFF_3F800000, 1);
    apply("R5 sign xor", 1, 2'b10, 64'hFFFFFFFF_BF800000, 64'hFFFFFFFF_C0000000, 64'hFFFFFFFF_3F800000, 1);
    apply("R9 idle after op", 0, 2'b00, 64'hFFFFFFFF_00000000, 64'hFFFFFFFF_80000000, 64'hFFFFFFFF_3F800000, 1);
    apply("R2 R6 unboxed A", 1, 2'b00, 64'h00000000_3F800000, 64'hFFFFFFFF_C0000000, 64'hFFFFFFFF_FFC00000, 1);
    apply("R2 unboxed B", 1, 2'b01, 64'hFFFFFFFF_BF800000, 64'h7FFFFFFF_80000000, 64'hFFFFFFFF_BF800000, 1);
    apply("R1 box one bit short", 1, 2'b10, 64'hFFFFFFFE_FF800000, 64'hFFFFFFFF_00000000, 64'hFFFFFFFF_7FC00000, 1);
    apply("R8 reserved", 1, 2'b11, 64'hFFFFFFFF_12345678, 64'hFFFFFFFF_87654321, 64'hFFFFFFFF_7FC00000, 1);
    apply("R7 move", 1, 2'b00, 64'hFFFFFFFF_C0490FDB, 64'hFFFFFFFF_C0490FDB, 64'hFFFFFFFF_C0490FDB, 1);
    apply("R7 negate", 1, 2'b01, 64'hFFFFFFFF_C0490FDB, 64'hFFFFFFFF_C0490FDB, 64'hFFFFFFFF_40490FDB, 1);
    apply("R7 abs", 1, 2'b10, 64'hFFFFFFFF_C0490FDB, 64'hFFFFFFFF_C0490FDB, 64'hFFFFFFFF_40490FDB, 1);
    apply("R7 R2 negate unboxed", 1, 2'b01, 64'h12345678_00000000, 64'h12345678_00000000, 64'hFFFFFFFF_FFC00000, 1);
    apply("R8 idle hold", 0, 2'b10, 64'hFFFFFFFF_00000001, 64'hFFFFFFFF_80000000, 64'hFFFFFFFF_FFC00000, 1);
    apply("R6 infinity sign xor", 1, 2'b10, 64'hFFFFFFFF_FF800000, 64'hFFFFFFFF_80000000, 64'hFFFFFFFF_7F800000, 1);

    for (int i = 0; i < 400; i++) begin
      logic [63:0] a = pick();
      logic [63:0] b = ($urandom % 5 == 0) ? a : pick();
      logic [1:0]  op = 2'($urandom % 4);
      logic        v = ($urandom % 6) != 0;
      apply("R3 R4 R5 R6 random", v, op, a, b, 64'd0, 0);
    end

    @(negedge clk); rst = 1'b1; in_valid = 1'b1; op_sel = 2'b00;
    @(posedge clk); #5;
    chk("R10 reset mid-run", {out_data[1:0], out_valid, fs_dirty} == 4'd0 ? out_data : 64'hDEAD, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule